// File: doc/BRIEF.md
# Four-Wide Macro-Instruction to Micro-Op Steering

This block sits between an instruction fetch queue and a micro-op queue. Each cycle it looks at up to four macro-instructions at the head of the fetch queue, each already tagged with the number of micro-ops it expands into. It forms the longest in-order group that the decoder layout allows and places the resulting micro-ops on four output lanes in program order. It also reports back to the fetch queue how many macro-instructions were taken, so that the queue can drop them before the next cycle.

The first decoder can expand one instruction into one to four micro-ops. The other three decoders handle only instructions that map to a single micro-op. An instruction that needs more micro-ops than four goes to a small microcode sequencer. That sequencer emits the instruction's micro-ops four per cycle until the sequence ends, and decoding pauses while it runs. A micro-op is encoded as the tag of its parent instruction joined with its index inside that instruction's sequence. This stands in for the contents of a microcode store.

Top module: `uop_steer`

## Requirements
- R1: After reset the sequencer is idle. With no valid input, no lane is valid and the consumed count is 0. A reset during a stream abandons the stream, and the next cycle decodes the fetch queue head.
- R2: A slot-0 instruction with a count of 1 to 4 emits exactly that many micro-ops on lanes 0 upward. Lane data is {tag[7:0], index[3:0]}, and the indices run 0, 1, 2 and so on.
- R3: Slot i (i = 1 to 3) joins the group only when it is valid, its count is exactly 1, and every earlier slot joined. It emits {tag, 0} on the next free lane.
- R4: The group also ends when all four lanes are taken. For example, a slot-0 count of 3 allows at most one following single-micro-op instruction.
- R5: A valid instruction after slot 0 with a count above 1 ends the group before it. The consumed count then equals its slot index, so it becomes slot 0 in the next cycle.
- R6: A slot-0 count above 4 consumes that one instruction and emits its micro-ops 0 to 3 in the same cycle. The later cycles emit the remaining indices, four per cycle, with the last cycle carrying only the remainder.
- R7: While the sequencer is streaming, the consumed count is 0 and the lanes carry only the stream, whatever the inputs are.
- R8: When out_ready is low, the consumed count is 0 and no state advances. The same micro-ops are offered again once out_ready returns, so nothing is lost or duplicated.
- R9: Valid lanes are always packed from lane 0 with no gaps, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Valid bits of the four fetch-queue head slots (a contiguous prefix) |
| in_tag | input | 32 | Per-slot instruction tag, 8 bits each, with slot 0 in the low bits |
| in_cnt | input | 16 | Per-slot micro-op count, 4 bits each, always 1 or more |
| out_ready | input | 1 | The micro-op queue accepts this cycle's lanes |
| uop_valid | output | 4 | Lane valid bits |
| uop_data | output | 48 | Per-lane micro-op {tag, index}, 12 bits each, with lane 0 in the low bits |
| consumed | output | 3 | Macro-instructions taken this cycle |

## Verification
The hardest situation to reach is backpressure or reset that lands in the middle of a microcode stream. It needs a long instruction at the queue head and a stall or reset in exactly the cycles that follow. The stimulus handles the stall case by mixing stretches of long instructions with an out_ready pattern that drops roughly one cycle in four, so stalls fall on the first, middle and last stream cycles. A one-shot reset fires in the first streaming cycle after a set point, and the reference model checks that decoding restarts at the unconsumed head.

// File: rtl/uop_steer.sv
module uop_steer #(
  parameter int W     = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [W-1:0]                  in_valid,
  input  logic [W*TAG_W-1:0]            in_tag,
  input  logic [W*CNT_W-1:0]            in_cnt,
  input  logic                          out_ready,
  output logic [W-1:0]                  uop_valid,
  output logic [W*(TAG_W+CNT_W)-1:0]    uop_data,
  output logic [$clog2(W+1)-1:0]        consumed
);
  localparam int UW = TAG_W + CNT_W;
  localparam int KW = $clog2(W+1);
  localparam logic [CNT_W-1:0] WIDE = CNT_W'(W);

  logic             seq_busy;
  logic [TAG_W-1:0] seq_tag;
  logic [CNT_W-1:0] seq_idx, seq_left;

  logic [TAG_W-1:0] tag  [W];
  logic [CNT_W-1:0] cnt  [W];
  logic [UW-1:0]    lane [W];
  logic [KW-1:0]    take;
  logic             start;
  logic             long0;

  for (genvar g = 0; g < W; g++) begin : g_slot
    assign tag[g] = in_tag[g*TAG_W +: TAG_W];
    assign cnt[g] = in_cnt[g*CNT_W +: CNT_W];
    assign uop_data[g*UW +: UW] = lane[g];
  end

  assign long0 = cnt[0] > WIDE;

  always_comb begin
    int   used;
    logic open;
    used      = 0;
    open      = 1'b1;
    uop_valid = '0;
    take      = '0;
    start     = 1'b0;
    for (int j = 0; j < W; j++) lane[j] = '0;
    if (seq_busy) begin
      for (int j = 0; j < W; j++)
        if (CNT_W'(j) < seq_left) begin
          uop_valid[j] = 1'b1;
          lane[j]      = {seq_tag, seq_idx + CNT_W'(j)};
        end
    end else if (in_valid[0]) begin
      take = KW'(1);
      if (long0) begin
        start = 1'b1;
        for (int j = 0; j < W; j++) begin
          uop_valid[j] = 1'b1;
          lane[j]      = {tag[0], CNT_W'(j)};
        end
      end else begin
        used = int'(cnt[0]);
        for (int j = 0; j < W; j++)
          if (CNT_W'(j) < cnt[0]) begin
            uop_valid[j] = 1'b1;
            lane[j]      = {tag[0], CNT_W'(j)};
          end
        for (int i = 1; i < W; i++) begin
          if (open && in_valid[i] && cnt[i] == CNT_W'(1) && used < W) begin
            uop_valid[used] = 1'b1;
            lane[used]      = {tag[i], CNT_W'(0)};
            used            = used + 1;
            take            = take + KW'(1);
          end else begin
            open = 1'b0;
          end
        end
      end
    end
  end

  assign consumed = out_ready ? take : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_busy <= 1'b0;
      seq_tag  <= '0;
      seq_idx  <= '0;
      seq_left <= '0;
    end else if (out_ready) begin
      if (seq_busy) begin
        seq_busy <= seq_left > WIDE;
        seq_left <= (seq_left > WIDE) ? seq_left - WIDE : '0;
        seq_idx  <= seq_idx + WIDE;
      end else if (start) begin
        seq_busy <= 1'b1;
        seq_tag  <= tag[0];
        seq_idx  <= WIDE;
        seq_left <= cnt[0] - WIDE;
      end
    end
  end
endmodule

// File: rtl/uop_steer_chk.sv
module uop_steer_chk #(
  parameter int W     = 4,
  parameter int CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [W-1:0]           in_valid,
  input logic [W*CNT_W-1:0]     in_cnt,
  input logic                   out_ready,
  input logic [W-1:0]           uop_valid,
  input logic [$clog2(W+1)-1:0] consumed,
  input logic                   seq_busy,
  input logic [CNT_W-1:0]       seq_left
);
  p_take_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(consumed) <= $countones(in_valid));

  p_stall_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> consumed == '0);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(seq_busy) && $stable(seq_left));

  p_stream_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> consumed == '0 && uop_valid[0]);

  p_packed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid & (uop_valid + 1'b1)) == '0);

  p_enter_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !seq_busy && in_valid[0] && in_cnt[CNT_W-1:0] > CNT_W'(W)
    |=> seq_busy);
endmodule

bind uop_steer uop_steer_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt),
  .out_ready(out_ready), .uop_valid(uop_valid), .consumed(consumed),
  .seq_busy(seq_busy), .seq_left(seq_left)
);

// File: tb/sim_uop_steer.sv
`timescale 1ns/1ps
module sim_uop_steer;
  localparam int NI = 320;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0;
  logic [31:0] in_tag = '0;
  logic [15:0] in_cnt = '0;
  logic        out_ready = 1'b0;
  logic [3:0]  uop_valid;
  logic [47:0] uop_data;
  logic [2:0]  consumed;

  int errors = 0;
  int checks = 0;
  int icnt [NI];
  int ptr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uop_steer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_cnt(in_cnt), .out_ready(out_ready), .uop_valid(uop_valid),
    .uop_data(uop_data), .consumed(consumed)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (ptr=%0d)", rq, act, exp, ptr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    int dir [20] = '{1,1,1,1, 2,1,1,1, 1,3,1, 4, 1, 9, 1,1, 15, 3,1,1};
    lf = 32'h1ace;
    for (int i = 0; i < NI; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      if (i < 20) icnt[i] = dir[i];
      else if ((lf & 15) < 9) icnt[i] = 1;
      else if ((lf & 15) < 14) icnt[i] = 2 + ((lf >> 4) % 3);
      else icnt[i] = 5 + ((lf >> 4) % 11);
    end
  end

  initial begin
    int mbusy, mtag, mnext, mleft, cyc, lf, did_rst;
    int exn, excons, c0, avail, rdy;
    int ex [4];
    string rq;
    mbusy = 0; mtag = 0; mnext = 0; mleft = 0; cyc = 0; did_rst = 0;
    lf = 32'h5eed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset with nothing presented
    chk("R1", int'(uop_valid), 0);
    chk("R1", int'(consumed), 0);

    while ((ptr < NI || mbusy) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      rdy = ((lf & 3) != 0) ? 1 : 0;
      // R1: reset once in the first streaming cycle after a set point
      if (!did_rst && mbusy && cyc > 100) begin
        did_rst = 1;
        rst_n = 1'b0;
        in_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;
        mbusy = 0;
      end
      out_ready = rdy[0];
      avail = NI - ptr;
      for (int i = 0; i < 4; i++) begin
        in_valid[i] = (i < avail);
        in_tag[i*8 +: 8] = (i < avail) ? 8'((ptr + i) & 255) : 8'h0;
        in_cnt[i*4 +: 4] = (i < avail) ? 4'(icnt[ptr + i]) : 4'h1;
      end
      exn = 0; excons = 0; c0 = 0;
      if (mbusy) begin
        rq = rdy ? "R7" : "R8";
        while (exn < 4 && exn < mleft) begin
          ex[exn] = (mtag << 4) | ((mnext + exn) & 15);
          exn++;
        end
      end else if (avail > 0) begin
        c0 = icnt[ptr];
        excons = 1;
        if (c0 > 4) begin
          rq = "R6";
          for (int j = 0; j < 4; j++) ex[j] = ((ptr & 255) << 4) | j;
          exn = 4;
        end else begin
          rq = "R3";
          for (int j = 0; j < c0; j++) ex[j] = ((ptr & 255) << 4) | j;
          exn = c0;
          for (int i = 1; i < 4; i++) begin
            if (i >= avail) break;
            if (icnt[ptr + i] != 1) begin rq = "R5"; break; end
            if (exn == 4) begin rq = "R4"; break; end
            ex[exn] = (((ptr + i) & 255) << 4);
            exn++;
            excons++;
          end
        end
        if (!rdy) rq = "R8";
      end else begin
        rq = "R8";
      end
      #1;
      chk(rq, int'(consumed), rdy ? excons : 0);
      chk({rq, " R9"}, int'(uop_valid), (1 << exn) - 1);
      for (int j = 0; j < exn; j++)
        chk("R2 R9", int'(uop_data[j*12 +: 12]), ex[j]);
      @(posedge clk);
      if (rdy) begin
        if (mbusy) begin
          mleft = mleft - 4;
          mnext = mnext + 4;
          if (mleft <= 0) mbusy = 0;
        end else if (c0 > 4) begin
          mbusy = 1;
          mtag = ptr & 255;
          mnext = 4;
          mleft = c0 - 4;
        end
        ptr = ptr + excons;
      end
    end
    chk("R8", ptr, NI);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule